// File: doc/BRIEF.md
# Alpha Blend Mixer

This block blends two 12-bit pixel streams with a 12-bit weight. Each clock it takes one pixel from each stream and produces `alpha*A + (1 - alpha)*B` on a 13-bit registered result, four clocks later. The weight is a 1.11 unsigned fixed-point number. It is kept in a register that loads only when `alpha_ld` is high, so one weight can serve a whole region of an image. A weight above 1.0 is stored as exactly 1.0.

The pixels of a sample are treated either as unsigned or as two's complement. The format is chosen per sample. A per-sample rounding select reduces the result to 8, 10, 12 or the full 13 significant bits. Both selects travel down the pipeline with their sample, so changing them never touches samples already in flight.

The weighted sum has one redundant top bit, because the weight cannot exceed 1.0. The block drops that bit and keeps one extra fraction bit instead. The result therefore carries the integer mix plus one half-LSB bit. An active-low output enable either presents the result or releases the output. A released output shows zero with `mix_drv` low.

Top module: `blend_mixer`

## Requirements
- R1: With `fmt_uns` high, the pixels are unsigned. Let S = a·A + (2048 − a)·B, where a is the stored weight (bit 11 weighs 1.0, bits 10..0 weigh 2^-1..2^-11). The result is bits 22..10 of S after rounding, which is the mix with one fraction bit.
- R2: With `fmt_uns` low, both pixels are two's complement. S is formed with signed pixels in the same way, and the 13-bit result is two's complement.
- R3: A weight value above 2048 (1.0) presented with `alpha_ld` high is stored as 2048. With such a load, A=0x123 gives a result of 0x246.
- R4: With `alpha_ld` low, the stored weight is held and used for every later sample. The value on `alpha_in` has no effect.
- R5: `rnd_sel` codes are 00 = keep 8 bits, 01 = keep 10, 10 = keep 12, 11 = keep 13. Rounding adds 1 at S bit 14, 12, 10 or 9 respectively, then clears that bit and every bit below it. The result's low 5, 3, 1 or 0 bits are therefore zero.
- R6: If the rounding addition carries past the largest value of the format (S above 2^23−1 unsigned, above 2^22−1 signed), the result saturates. It becomes the largest value of the format with the cleared bits of R5 at zero; for example 0x1FE0 unsigned or 0x0FE0 signed with code 00.
- R7: Format and rounding selects are captured with their sample. Consecutive samples with different selects each get their own treatment.
- R8: A sample captured at clock edge N appears on `mix_out` after edge N+3 and not earlier.
- R9: With `out_en_n` low, `mix_out` shows the result and `mix_drv` is high. With `out_en_n` high, `mix_out` is zero and `mix_drv` is low.
- R10: After reset the stored weight is 0 and the result register is 0. A first sample without a weight load therefore yields B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_a | input | 12 | First pixel stream (weighted by alpha) |
| pix_b | input | 12 | Second pixel stream (weighted by 1 − alpha) |
| alpha_in | input | 12 | New weight, 1.11 unsigned |
| alpha_ld | input | 1 | Load enable for the weight register |
| fmt_uns | input | 1 | 1 = unsigned pixels, 0 = two's complement |
| rnd_sel | input | 2 | Rounding select, see R5 |
| out_en_n | input | 1 | Active-low output enable |
| mix_out | output | 13 | Mixed result, zero when released |
| mix_drv | output | 1 | High while `mix_out` is driven |

## Verification
The hardest situation to reach is saturation in the rounding step. It needs a sum within one rounding increment of the format limit, such as both pixels at full scale under a half weight, or a positive full-scale pixel under a weight of 1.0. The stimulus builds these sums on purpose in both formats. The other hard case is a weight held across samples while the weight bus carries a different, over-range value. The stream therefore mixes held and loaded weights with changing format and rounding selects on back-to-back samples.

// File: rtl/blend_pkg.sv
`timescale 1ns/1ps
package blend_pkg;

  typedef enum logic [1:0] {
    RND_KEEP8  = 2'b00,
    RND_KEEP10 = 2'b01,
    RND_KEEP12 = 2'b10,
    RND_KEEP13 = 2'b11
  } rnd_mode_e;

  // number of low result bits forced to zero for a rounding mode
  function automatic int unsigned cleared_bits(input rnd_mode_e m);
    case (m)
      RND_KEEP8:  return 5;
      RND_KEEP10: return 3;
      RND_KEEP12: return 1;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/blend_rst_sync.sv
`timescale 1ns/1ps
module blend_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/blend_alpha_reg.sv
`timescale 1ns/1ps
module blend_alpha_reg #(
  parameter int ALPHA_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ALPHA_W-1:0] alpha_in,
  output logic [ALPHA_W-1:0] alpha_q
);
  localparam logic [ALPHA_W-1:0] UNITY = {1'b1, {(ALPHA_W-1){1'b0}}};

  logic [ALPHA_W-1:0] clamped;
  logic [ALPHA_W-1:0] alpha_d;

  always_comb begin
    clamped = (alpha_in > UNITY) ? UNITY : alpha_in;
    alpha_d = load ? clamped : alpha_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alpha_q <= '0;
    else        alpha_q <= alpha_d;
  end
endmodule

// File: rtl/blend_lane_mult.sv
`timescale 1ns/1ps
module blend_lane_mult #(
  parameter int PIX_W   = 12,
  parameter int ALPHA_W = 12,
  localparam int PROD_W = PIX_W + ALPHA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIX_W-1:0]         pix,
  input  logic                     fmt_uns,
  input  logic [ALPHA_W-1:0]       weight,
  output logic signed [PROD_W-1:0] prod_q
);
  logic signed [PIX_W:0]       pix_ext;
  logic signed [ALPHA_W:0]     w_ext;
  logic signed [PROD_W-1:0]    prod_d;

  always_comb begin
    pix_ext = signed'({fmt_uns ? 1'b0 : pix[PIX_W-1], pix});
    w_ext   = signed'({1'b0, weight});
    prod_d  = PROD_W'(pix_ext * w_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end
endmodule

// File: rtl/blend_round.sv
`timescale 1ns/1ps
module blend_round #(
  parameter int SUM_W     = 27,
  parameter int FRAME_MSB = 22,
  parameter int OUT_W     = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SUM_W-1:0] sum,
  input  logic                    fmt_uns,
  input  blend_pkg::rnd_mode_e    rnd,
  output logic [OUT_W-1:0]        res_q
);
  import blend_pkg::*;

  localparam int FRAME_LSB = FRAME_MSB - OUT_W + 1;
  localparam int RW        = SUM_W + 1;

  logic signed [RW-1:0] widened;
  logic signed [RW-1:0] inc;
  logic signed [RW-1:0] keep_mask;
  logic signed [RW-1:0] rounded;
  logic [OUT_W-1:0]     out_mask;
  logic [OUT_W-1:0]     sat_val;
  logic                 ovf;
  logic [OUT_W-1:0]     res_d;
  int unsigned          clr;
  int unsigned          pos;

  always_comb begin
    clr       = cleared_bits(rnd);
    pos       = FRAME_LSB - 1 + clr;
    widened   = RW'(sum);
    inc       = RW'(1) << pos;
    keep_mask = ~((RW'(1) << (pos + 1)) - RW'(1));
    rounded   = (widened + inc) & keep_mask;
    if (fmt_uns) ovf = !rounded[RW-1] && (|rounded[RW-2:FRAME_MSB+1]);
    else         ovf = !rounded[RW-1] && (|rounded[RW-2:FRAME_MSB]);
    out_mask  = {OUT_W{1'b1}} << clr;
    sat_val   = fmt_uns ? {OUT_W{1'b1}} : {1'b0, {(OUT_W-1){1'b1}}};
    res_d     = ovf ? (sat_val & out_mask) : rounded[FRAME_MSB:FRAME_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end
endmodule

// File: rtl/blend_mixer.sv
`timescale 1ns/1ps
module blend_mixer #(
  parameter int PIX_W   = 12,
  parameter int ALPHA_W = 12,
  parameter int OUT_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIX_W-1:0]   pix_a,
  input  logic [PIX_W-1:0]   pix_b,
  input  logic [ALPHA_W-1:0] alpha_in,
  input  logic               alpha_ld,
  input  logic               fmt_uns,
  input  logic [1:0]         rnd_sel,
  input  logic               out_en_n,
  output logic [OUT_W-1:0]   mix_out,
  output logic               mix_drv
);
  import blend_pkg::*;

  localparam int PROD_W    = PIX_W + ALPHA_W + 2;
  localparam int SUM_W     = PROD_W + 1;
  localparam int FRAME_MSB = PIX_W + ALPHA_W - 2;
  localparam int LANES     = 2;
  localparam logic [ALPHA_W-1:0] UNITY = {1'b1, {(ALPHA_W-1){1'b0}}};

  logic rst_i_n;
  blend_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // stage 1: capture
  logic [ALPHA_W-1:0] alpha_q;
  logic [PIX_W-1:0]   pix_q   [LANES];
  logic [PIX_W-1:0]   pix_d   [LANES];
  logic               fmt_s1_q, fmt_s2_q, fmt_s3_q;
  rnd_mode_e          rnd_s1_q, rnd_s2_q, rnd_s3_q;

  blend_alpha_reg #(.ALPHA_W(ALPHA_W)) u_alpha (
    .clk(clk), .rst_n(rst_i_n), .load(alpha_ld),
    .alpha_in(alpha_in), .alpha_q(alpha_q)
  );

  always_comb begin
    pix_d[0] = pix_a;
    pix_d[1] = pix_b;
  end

  // stage 2: products, one lane per input stream
  logic [ALPHA_W-1:0]       weight [LANES];
  logic signed [PROD_W-1:0] prod_q [LANES];

  always_comb begin
    weight[0] = alpha_q;
    weight[1] = UNITY - alpha_q;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) pix_q[g] <= '0;
      else          pix_q[g] <= pix_d[g];
    end

    blend_lane_mult #(.PIX_W(PIX_W), .ALPHA_W(ALPHA_W)) u_mult (
      .clk(clk), .rst_n(rst_i_n), .pix(pix_q[g]), .fmt_uns(fmt_s1_q),
      .weight(weight[g]), .prod_q(prod_q[g])
    );
  end

  // stage 3: sum
  logic signed [SUM_W-1:0] sum_d, sum_q;

  always_comb sum_d = SUM_W'(prod_q[0]) + SUM_W'(prod_q[1]);

  // control pipeline and sum register
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fmt_s1_q <= 1'b0;
      fmt_s2_q <= 1'b0;
      fmt_s3_q <= 1'b0;
      rnd_s1_q <= RND_KEEP8;
      rnd_s2_q <= RND_KEEP8;
      rnd_s3_q <= RND_KEEP8;
      sum_q    <= '0;
    end else begin
      fmt_s1_q <= fmt_uns;
      fmt_s2_q <= fmt_s1_q;
      fmt_s3_q <= fmt_s2_q;
      rnd_s1_q <= rnd_mode_e'(rnd_sel);
      rnd_s2_q <= rnd_s1_q;
      rnd_s3_q <= rnd_s2_q;
      sum_q    <= sum_d;
    end
  end

  // stage 4: adjust (frame select) and round
  logic [OUT_W-1:0] res_q;

  blend_round #(.SUM_W(SUM_W), .FRAME_MSB(FRAME_MSB), .OUT_W(OUT_W)) u_round (
    .clk(clk), .rst_n(rst_i_n), .sum(sum_q), .fmt_uns(fmt_s3_q),
    .rnd(rnd_s3_q), .res_q(res_q)
  );

  always_comb begin
    mix_drv = !out_en_n;
    mix_out = out_en_n ? '0 : res_q;
  end
endmodule

// File: rtl/blend_mixer_chk.sv
`timescale 1ns/1ps
module blend_mixer_chk #(
  parameter int ALPHA_W = 12,
  parameter int OUT_W   = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alpha_ld,
  input logic [1:0]         rnd_sel,
  input logic               out_en_n,
  input logic [ALPHA_W-1:0] alpha_q,
  input logic [OUT_W-1:0]   res_q,
  input logic [OUT_W-1:0]   mix_out,
  input logic               mix_drv
);
  localparam logic [ALPHA_W-1:0] UNITY = {1'b1, {(ALPHA_W-1){1'b0}}};

  // R3
  alpha_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alpha_q <= UNITY);

  // R4
  alpha_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alpha_ld |=> $stable(alpha_q));

  // R5
  round8_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rnd_sel, 4) == 2'b00) |-> (res_q[4:0] == 5'd0));

  // R5
  round10_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rnd_sel, 4) == 2'b01) |-> (res_q[2:0] == 3'd0));

  // R9
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (mix_out == '0 && !mix_drv));

  // R9
  driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_n |-> (mix_out == res_q && mix_drv));
endmodule

bind blend_mixer blend_mixer_chk #(.ALPHA_W(ALPHA_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alpha_ld(alpha_ld), .rnd_sel(rnd_sel),
  .out_en_n(out_en_n), .alpha_q(alpha_q), .res_q(res_q),
  .mix_out(mix_out), .mix_drv(mix_drv)
);

// File: tb/blend_mixer_test.sv
`timescale 1ns/1ps
module blend_mixer_test;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] pix_a, pix_b, alpha_in;
  logic        alpha_ld, fmt_uns, out_en_n;
  logic [1:0]  rnd_sel;
  logic [12:0] mix_out;
  logic        mix_drv;

  int checks = 0;
  int fails  = 0;
  int model_alpha = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  blend_mixer uut (
    .clk(clk), .rst_n(rst_n), .pix_a(pix_a), .pix_b(pix_b),
    .alpha_in(alpha_in), .alpha_ld(alpha_ld), .fmt_uns(fmt_uns),
    .rnd_sel(rnd_sel), .out_en_n(out_en_n), .mix_out(mix_out),
    .mix_drv(mix_drv)
  );

  // {ld, fmt_uns, rnd, alpha, A, B}
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'b11, 12'hFFF, 12'h321, 12'h0AB},
    {1'b1, 1'b1, 2'b11, 12'h400, 12'h101, 12'h200},
    {1'b0, 1'b1, 2'b00, 12'h000, 12'h0F0, 12'h00F},
    {1'b0, 1'b1, 2'b01, 12'hFFF, 12'h777, 12'h111},
    {1'b1, 1'b0, 2'b10, 12'h300, 12'hF00, 12'h0FF},
    {1'b0, 1'b0, 2'b11, 12'h123, 12'h800, 12'h7FF},
    {1'b1, 1'b1, 2'b10, 12'hC00, 12'hABC, 12'h123},
    {1'b1, 1'b0, 2'b00, 12'h001, 12'h555, 12'hAAA},
    {1'b1, 1'b1, 2'b00, 12'h400, 12'hFFF, 12'hFFF},
    {1'b0, 1'b0, 2'b01, 12'h000, 12'h7FF, 12'h7FF},
    {1'b1, 1'b0, 2'b11, 12'h7FF, 12'h800, 12'h001},
    {1'b0, 1'b1, 2'b11, 12'h000, 12'h800, 12'h001},
    {1'b1, 1'b0, 2'b00, 12'h800, 12'h7FF, 12'h000},
    {1'b1, 1'b1, 2'b01, 12'h5A5, 12'h3C3, 12'hC3C},
    {1'b0, 1'b0, 2'b10, 12'h0F0, 12'hFFF, 12'h001},
    {1'b1, 1'b1, 2'b11, 12'h801, 12'h0CC, 12'hFFF}
  };

  function automatic int sx(input int v, input bit uns);
    return (!uns && v >= 2048) ? v - 4096 : v;
  endfunction

  function automatic logic [12:0] ref_mix(input int a, input bit uns,
      input int rnd, input int pa, input int pb);
    int s, pos, r, clr, lim;
    logic [12:0] sat;
    s   = a * sx(pa, uns) + (2048 - a) * sx(pb, uns);
    clr = (rnd == 0) ? 5 : (rnd == 1) ? 3 : (rnd == 2) ? 1 : 0;
    pos = 9 + clr;
    r   = (s + (1 << pos)) & ~((1 << (pos + 1)) - 1);
    lim = uns ? 32'h7FFFFF : 32'h3FFFFF;
    if (r > lim) begin
      sat = uns ? 13'h1FFF : 13'h0FFF;
      return sat & (13'h1FFF << clr);
    end
    return 13'((r >>> 10) & 32'h1FFF);
  endfunction

  task automatic check(input string tag, input logic [12:0] got,
      input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input bit ld, input bit uns, input logic [1:0] rnd,
      input logic [11:0] al, input logic [11:0] a, input logic [11:0] b);
    alpha_ld = ld; fmt_uns = uns; rnd_sel = rnd;
    alpha_in = al; pix_a = a; pix_b = b;
    if (ld) model_alpha = (al > 12'h800) ? 2048 : int'(al);
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 2'b11, 12'hFFF, 12'h000, 12'h000);
  endtask

  // one sample, then idle; result sampled after the fourth edge
  task automatic single(input bit ld, input bit uns, input logic [1:0] rnd,
      input logic [11:0] al, input logic [11:0] a, input logic [11:0] b,
      input logic [12:0] exp, input string tag);
    @(negedge clk);
    drive(ld, uns, rnd, al, a, b);
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    check(tag, mix_out, exp);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [12:0] exp_q [NV];
    rst_n = 1'b0; out_en_n = 1'b0;
    drive(1'b0, 1'b1, 2'b11, 12'h000, 12'h000, 12'h000);
    model_alpha = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state of the result and drive flag
    check("R10 reset result", mix_out, 13'h000);
    check("R9 drive flag after reset", {12'd0, mix_drv}, 13'h001);

    // stream: one sample per clock, results checked four edges later
    for (int j = 0; j < NV + 4; j++) begin
      if (j >= 4) begin
        logic [39:0] v;
        v = VEC[j-4];
        // R1 or R2 by format, R7 per-sample selects, R3 R4 weight handling
        check(v[38] ? "R1 R7 stream unsigned" : "R2 R7 stream signed",
              mix_out, exp_q[j-4]);
      end
      if (j < NV) begin
        logic [39:0] v;
        v = VEC[j];
        drive(v[39], v[38], v[37:36], v[35:24], v[23:12], v[11:0]);
        exp_q[j] = ref_mix(model_alpha, v[38], int'(v[37:36]),
                           int'(v[23:12]), int'(v[11:0]));
      end else begin
        idle();
      end
      @(negedge clk);
    end

    // R8: latency, from a known zero output
    @(negedge clk);
    drive(1'b1, 1'b1, 2'b11, 12'h800, 12'h000, 12'h000);
    repeat (4) @(negedge clk);
    drive(1'b0, 1'b1, 2'b11, 12'h000, 12'h123, 12'h456);
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
    check("R8 not after third edge", mix_out, 13'h000);
    @(negedge clk);
    check("R8 after fourth edge", mix_out, 13'h246);

    // R9: release and drive again
    out_en_n = 1'b1;
    #1;
    check("R9 released value", mix_out, 13'h000);
    check("R9 released flag", {12'd0, mix_drv}, 13'h000);
    out_en_n = 1'b0;
    #1;
    check("R9 driven again", mix_out, 13'h246);

    // R3: over-range weight is clamped to 1.0
    single(1'b1, 1'b1, 2'b11, 12'hFFF, 12'h123, 12'h456, 13'h246, "R3 clamp");
    // R4: weight held at 0 while the bus carries an over-range value
    single(1'b1, 1'b1, 2'b11, 12'h000, 12'h000, 12'h000, 13'h000, "R4 load zero");
    single(1'b0, 1'b1, 2'b11, 12'hFFF, 12'h100, 12'h050, 13'h0A0, "R4 hold");
    // R5: rounding by mode, B only (S = 0x5800)
    single(1'b0, 1'b1, 2'b00, 12'h000, 12'h000, 12'h00B, 13'h020, "R5 keep8");
    single(1'b0, 1'b1, 2'b01, 12'h000, 12'h000, 12'h00B, 13'h018, "R5 keep10");
    single(1'b0, 1'b1, 2'b10, 12'h000, 12'h000, 12'h00B, 13'h016, "R5 keep12");
    single(1'b0, 1'b1, 2'b11, 12'h000, 12'h000, 12'h00B, 13'h016, "R5 keep13");
    // R1 R5: half weight on 1 gives the half bit; keep12 rounds it up
    single(1'b1, 1'b1, 2'b11, 12'h400, 12'h001, 12'h000, 13'h001, "R1 half bit");
    single(1'b0, 1'b1, 2'b10, 12'h400, 12'h001, 12'h000, 13'h002, "R5 round up");
    // R6: saturation in both formats
    single(1'b1, 1'b1, 2'b00, 12'h400, 12'hFFF, 12'hFFF, 13'h1FE0, "R6 unsigned sat");
    single(1'b1, 1'b0, 2'b00, 12'h800, 12'h7FF, 12'h000, 13'h0FE0, "R6 signed sat");
    // R2: most negative pixel under full weight
    single(1'b0, 1'b0, 2'b11, 12'h800, 12'h800, 12'h000, 13'h1000, "R2 negative");

    done = 1;
    finish_run();
  end
endmodule